// File: doc/BRIEF.md
# Circuit-Switched Mesh Tile Switch

This block is the routing switch inside one tile of a two-dimensional processor mesh. Each of the four neighbour directions brings in two 16-bit channels, for eight link inputs. The local core adds two transmit streams. Eight outgoing links and two local receive queues pick their source from these ten streams. The picks come from configuration registers that software writes. No word carries an address. Once a path is configured, every word on that source follows it at one word per cycle. Traffic that crosses the tile never passes through the core's receive queues, so it does not disturb the core.

Every stream uses valid and ready. A word leaves its source only when every consumer that selects that source is ready, so one source can feed several consumers in lockstep. A ready deassertion therefore travels back along the configured path. Each outgoing link can add one register stage for long wires. That stage is a small state machine with two states. `ST_EMPTY` moves to `ST_FULL` when it takes in a word. `ST_FULL` stays in `ST_FULL` while it is stalled, or when it hands a word on and takes in the next one in the same cycle. `ST_FULL` returns to `ST_EMPTY` when it hands a word on and takes in none, or when the stage is switched off. The two local receive queues are FIFOs of 64 words, and the core drains them with a pop strobe.

Top module: `mesh_tile_switch`

## Requirements
- R1: After reset, every outgoing link valid, every link and core-transmit ready, and both receive-queue valids are low.
- R2: A consumer whose select code is 10 to 15 receives no source. Codes 0-7 select link inputs 0-7, and codes 8 and 9 select core transmit streams 0 and 1. An outgoing link in this state, with its register stage off, drives valid low.
- R3: With its register stage off, an outgoing link presents its selected source's data and valid in the same cycle. The source sees ready in that cycle.
- R4: With its register stage on, a word accepted in one cycle appears on the outgoing link in the next cycle. Back-to-back words flow at one word per cycle.
- R5: When a registered outgoing link holds a word that is not taken, the word stays stable and valid, and the source sees ready low until the link takes it.
- R6: A source selected by several consumers is accepted only in a cycle when all of them are ready. Until then, no consumer sees it as valid.
- R7: Receive selector q (configuration index 8+q) takes link inputs 0-7 only. Its FIFO returns the words in arrival order. It holds 64 words and drops the source's ready once it is full.
- R8: A source that no consumer selects sees ready low.
- R9: A configuration write with an index of 10 or more changes nothing. A receive selector given a code of 8 or more selects nothing.
- R10: The core transmit streams (codes 8 and 9) can be routed to any outgoing link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Consumer index: 0-7 outgoing links, 8-9 receive selectors |
| cfg_src | input | 4 | Source select code |
| cfg_pipe | input | 1 | Register-stage enable for an outgoing link |
| lnk_in_data | input | 8x16 | Link input words |
| lnk_in_valid | input | 8 | Link input valid |
| lnk_in_ready | output | 8 | Link input ready |
| core_tx_data | input | 2x16 | Core transmit words |
| core_tx_valid | input | 2 | Core transmit valid |
| core_tx_ready | output | 2 | Core transmit ready |
| lnk_out_data | output | 8x16 | Outgoing link words |
| lnk_out_valid | output | 8 | Outgoing link valid |
| lnk_out_ready | input | 8 | Outgoing link ready |
| core_rx_data | output | 2x16 | Head word of each receive FIFO |
| core_rx_valid | output | 2 | Receive FIFO not empty |
| core_rx_pop | input | 2 | Receive FIFO pop strobe |

## Verification
The hardest case to reach is a registered stage sitting in `ST_FULL` while its downstream is stalled and its upstream already offers the next word. In that case the stage must hold its word and refuse the new one. The bench reaches this case by streaming a word into a registered link and lowering that link's ready in the same cycle as it offers a second word. It then checks that the held word stays and that the source's ready is low. The full-FIFO boundary gets similar treatment: exactly 64 accepted pushes on a receive selector, followed by a check that the 65th is refused.

// File: rtl/tile_sw_pkg.sv
package tile_sw_pkg;
    localparam int unsigned NLINK = 8;
    localparam int unsigned NTX   = 2;
    localparam int unsigned NRX   = 2;
    localparam int unsigned NSRC  = NLINK + NTX;
    localparam int unsigned NCON  = NLINK + NRX;
    localparam int unsigned SELW  = 4;
    localparam int unsigned IDXW  = 4;
    typedef logic [SELW-1:0] sel_t;
    localparam sel_t SEL_NONE = '1;
endpackage

// File: rtl/tile_sw_cfg.sv
module tile_sw_cfg
    import tile_sw_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDXW-1:0]            idx,
    input  logic [SELW-1:0]            src,
    input  logic                       pipe,
    output logic [NCON-1:0][SELW-1:0]  sel,
    output logic [NLINK-1:0]           pipe_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCON; c++) sel[c] <= SEL_NONE;
            pipe_en <= '0;
        end else if (we) begin
            for (int c = 0; c < NCON; c++)
                if (idx == IDXW'(c)) sel[c] <= src;
            for (int c = 0; c < NLINK; c++)
                if (idx == IDXW'(c)) pipe_en[c] <= pipe;
        end
    end
endmodule

// File: rtl/tile_sw_pipe.sv
module tile_sw_pipe #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    typedef enum logic {ST_EMPTY, ST_FULL} stage_st_t;
    stage_st_t st, st_nxt;
    logic [W-1:0] q;
    logic         take;

    assign take = en && in_valid && ((st == ST_EMPTY) || out_ready);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_EMPTY: if (take) st_nxt = ST_FULL;
            ST_FULL:  if (!en) st_nxt = ST_EMPTY;
                      else if (out_ready && !take) st_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_EMPTY;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (take) q <= in_data;
    end

    always_comb begin
        if (en) begin
            out_valid = (st == ST_FULL);
            out_data  = q;
            in_ready  = (st == ST_EMPTY) || out_ready;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
            in_ready  = out_ready;
        end
    end

    // R5: a stalled full stage keeps its word
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_FULL && !out_ready) |=> (!en || (out_valid && $stable(out_data))));

    // R4: an accepted word shows up one cycle later
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_valid && in_ready) |=> (!en || (out_valid && out_data == $past(in_data))));
endmodule

// File: rtl/tile_sw_fifo.sv
module tile_sw_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         nonempty
);
    localparam int unsigned AW = $clog2(DEPTH);
    logic [W-1:0]  mem [DEPTH];
    logic [AW:0]   wp, rp, cnt;

    assign cnt      = wp - rp;
    assign full     = (cnt == (AW+1)'(DEPTH));
    assign nonempty = (cnt != '0);
    assign dout     = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full)   wp <= wp + 1'b1;
            if (pop && nonempty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end

    // R7: the switch never pushes into a full queue
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: occupancy stays within depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/mesh_tile_switch.sv
module mesh_tile_switch
    import tile_sw_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned FIFO_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDXW-1:0]               cfg_idx,
    input  logic [SELW-1:0]               cfg_src,
    input  logic                          cfg_pipe,
    input  logic [NLINK-1:0][WORD_W-1:0]  lnk_in_data,
    input  logic [NLINK-1:0]              lnk_in_valid,
    output logic [NLINK-1:0]              lnk_in_ready,
    input  logic [NTX-1:0][WORD_W-1:0]    core_tx_data,
    input  logic [NTX-1:0]                core_tx_valid,
    output logic [NTX-1:0]                core_tx_ready,
    output logic [NLINK-1:0][WORD_W-1:0]  lnk_out_data,
    output logic [NLINK-1:0]              lnk_out_valid,
    input  logic [NLINK-1:0]              lnk_out_ready,
    output logic [NRX-1:0][WORD_W-1:0]    core_rx_data,
    output logic [NRX-1:0]                core_rx_valid,
    input  logic [NRX-1:0]                core_rx_pop
);
    logic [NCON-1:0][SELW-1:0]   sel;
    logic [NLINK-1:0]            pipe_en;
    logic [NSRC-1:0]             sv, src_ready, src_used, all_rdy, src_go;
    logic [NSRC-1:0][WORD_W-1:0] sd;
    logic [NCON-1:0]             code_ok, c_valid, c_ready;
    logic [NCON-1:0][WORD_W-1:0] c_data;
    logic [NRX-1:0]              rx_full;

    tile_sw_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .src(cfg_src), .pipe(cfg_pipe), .sel(sel), .pipe_en(pipe_en)
    );

    assign sv = {core_tx_valid, lnk_in_valid};
    always_comb begin
        for (int s = 0; s < NLINK; s++) sd[s] = lnk_in_data[s];
        for (int t = 0; t < NTX; t++)   sd[NLINK+t] = core_tx_data[t];
    end

    // legal codes: outputs take any source, receive selectors only links
    always_comb begin
        for (int c = 0; c < NCON; c++)
            code_ok[c] = (c < NLINK) ? (sel[c] < SELW'(NSRC)) : (sel[c] < SELW'(NLINK));
    end

    // lockstep acceptance across every consumer of a source
    always_comb begin
        all_rdy  = '1;
        src_used = '0;
        for (int c = 0; c < NCON; c++)
            for (int s = 0; s < NSRC; s++)
                if (code_ok[c] && sel[c] == SELW'(s)) begin
                    all_rdy[s]  = all_rdy[s] & c_ready[c];
                    src_used[s] = 1'b1;
                end
    end
    assign src_ready = all_rdy & src_used;
    assign src_go    = sv & src_ready;
    assign lnk_in_ready  = src_ready[NLINK-1:0];
    assign core_tx_ready = src_ready[NSRC-1:NLINK];

    always_comb begin
        for (int c = 0; c < NCON; c++) begin
            c_valid[c] = code_ok[c] ? src_go[sel[c]] : 1'b0;
            c_data[c]  = code_ok[c] ? sd[sel[c]] : '0;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NLINK; g++) begin : g_out
            tile_sw_pipe #(.W(WORD_W)) u_pipe (
                .clk(clk), .rst_n(rst_n), .en(pipe_en[g]),
                .in_valid(c_valid[g]), .in_data(c_data[g]), .in_ready(c_ready[g]),
                .out_valid(lnk_out_valid[g]), .out_data(lnk_out_data[g]),
                .out_ready(lnk_out_ready[g])
            );

            // R2: an unrouted unregistered link stays idle
            a_r2_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
                (!code_ok[g] && !pipe_en[g]) |-> !lnk_out_valid[g]);

            // R6: an unregistered link only offers a word when it can be taken
            a_r6_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
                (!pipe_en[g] && lnk_out_valid[g]) |-> lnk_out_ready[g]);
        end
        for (g = 0; g < NRX; g++) begin : g_rx
            assign c_ready[NLINK+g] = !rx_full[g];
            tile_sw_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk(clk), .rst_n(rst_n),
                .push(c_valid[NLINK+g]), .din(c_data[NLINK+g]), .full(rx_full[g]),
                .pop(core_rx_pop[g]), .dout(core_rx_data[g]), .nonempty(core_rx_valid[g])
            );
        end
    endgenerate
endmodule

// File: tb/tb_mesh_tile_switch.sv
module tb_mesh_tile_switch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_idx = '0, cfg_src = '0;
    logic cfg_pipe = 1'b0;
    logic [7:0][15:0] lnk_in_data = '0;
    logic [7:0] lnk_in_valid = '0;
    logic [7:0] lnk_in_ready;
    logic [1:0][15:0] core_tx_data = '0;
    logic [1:0] core_tx_valid = '0;
    logic [1:0] core_tx_ready;
    logic [7:0][15:0] lnk_out_data;
    logic [7:0] lnk_out_valid;
    logic [7:0] lnk_out_ready = '1;
    logic [1:0][15:0] core_rx_data;
    logic [1:0] core_rx_valid;
    logic [1:0] core_rx_pop = '0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mesh_tile_switch dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int src, input bit p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_src = 4'(src); cfg_pipe = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk(lnk_out_valid == 0, "R1 out valid", int'(lnk_out_valid), 0);
        chk(lnk_in_ready == 0, "R1 in ready", int'(lnk_in_ready), 0);
        chk(core_tx_ready == 0, "R1 tx ready", int'(core_tx_ready), 0);
        chk(core_rx_valid == 0, "R1 rx valid", int'(core_rx_valid), 0);
    endtask

    task automatic t_bypass();
        cfg(3, 5, 0);
        @(negedge clk);
        lnk_in_valid[5] = 1'b1; lnk_in_data[5] = 16'hA5A5; #1;
        chk(lnk_out_valid[3] && lnk_out_data[3] == 16'hA5A5, "R3 bypass data", int'(lnk_out_data[3]), 16'hA5A5);
        chk(lnk_in_ready[5], "R3 source ready", int'(lnk_in_ready[5]), 1);
        chk(!lnk_out_valid[0], "R2 unrouted idle", int'(lnk_out_valid[0]), 0);
        @(negedge clk);
        lnk_out_ready[3] = 1'b0; #1;
        chk(!lnk_in_ready[5], "R5 backpressure bypass", int'(lnk_in_ready[5]), 0);
        @(negedge clk);
        lnk_in_valid[5] = 1'b0; lnk_out_ready[3] = 1'b1;
    endtask

    task automatic t_pipe();
        cfg(6, 2, 1);
        @(negedge clk);
        lnk_in_valid[2] = 1'b1; lnk_in_data[2] = 16'h0B0B; #1;
        chk(!lnk_out_valid[6], "R4 no same-cycle output", int'(lnk_out_valid[6]), 0);
        for (int k = 1; k < 3; k++) begin
            @(negedge clk);
            lnk_in_data[2] = 16'h0B0B + 16'(k); #1;
            chk(lnk_out_valid[6] && lnk_out_data[6] == 16'h0B0B + 16'(k-1), "R4 stream",
                int'(lnk_out_data[6]), 16'h0B0B + k - 1);
        end
        @(negedge clk);
        lnk_in_valid[2] = 1'b0; #1;
        chk(lnk_out_valid[6] && lnk_out_data[6] == 16'h0B0D, "R4 last word", int'(lnk_out_data[6]), 16'h0B0D);
        @(negedge clk);
        lnk_out_ready[6] = 1'b0; lnk_in_valid[2] = 1'b1; lnk_in_data[2] = 16'h00E0;
        @(negedge clk);
        lnk_in_data[2] = 16'h00F0; #1;
        chk(lnk_out_valid[6] && lnk_out_data[6] == 16'h00E0, "R5 held word", int'(lnk_out_data[6]), 16'h00E0);
        chk(!lnk_in_ready[2], "R5 full stage refuses", int'(lnk_in_ready[2]), 0);
        @(negedge clk); #1;
        chk(lnk_out_data[6] == 16'h00E0, "R5 still held", int'(lnk_out_data[6]), 16'h00E0);
        lnk_out_ready[6] = 1'b1;
        @(negedge clk);
        lnk_in_valid[2] = 1'b0; #1;
        chk(lnk_out_valid[6] && lnk_out_data[6] == 16'h00F0, "R5 next after release", int'(lnk_out_data[6]), 16'h00F0);
        @(negedge clk);
    endtask

    task automatic t_multicast();
        cfg(1, 7, 0);
        cfg(4, 7, 0);
        @(negedge clk);
        lnk_in_valid[7] = 1'b1; lnk_in_data[7] = 16'h7777; lnk_out_ready[4] = 1'b0; #1;
        chk(!lnk_in_ready[7], "R6 one consumer stalls source", int'(lnk_in_ready[7]), 0);
        chk(!lnk_out_valid[1], "R6 no partial delivery", int'(lnk_out_valid[1]), 0);
        @(negedge clk);
        lnk_out_ready[4] = 1'b1; #1;
        chk(lnk_out_valid[1] && lnk_out_valid[4] && lnk_out_data[4] == 16'h7777, "R6 joint delivery",
            int'({lnk_out_valid[1], lnk_out_valid[4]}), 3);
        @(negedge clk);
        lnk_in_valid[7] = 1'b0;
    endtask

    task automatic t_unused();
        @(negedge clk);
        lnk_in_valid[4] = 1'b1; #1;
        chk(!lnk_in_ready[4], "R8 unselected source", int'(lnk_in_ready[4]), 0);
        cfg(12, 4, 0);
        #1;
        chk(!lnk_in_ready[4], "R9 out-of-range index ignored", int'(lnk_in_ready[4]), 0);
        lnk_in_valid[4] = 1'b0;
        cfg(9, 9, 0);
        core_tx_valid[1] = 1'b1; #1;
        chk(!core_tx_ready[1], "R9 receive selector rejects code 9", int'(core_tx_ready[1]), 0);
        @(negedge clk); @(negedge clk); #1;
        chk(!core_rx_valid[1], "R9 receive queue empty", int'(core_rx_valid[1]), 0);
        core_tx_valid[1] = 1'b0;
    endtask

    task automatic t_core_tx();
        cfg(2, 8, 0);
        @(negedge clk);
        core_tx_valid[0] = 1'b1; core_tx_data[0] = 16'hC0DE; #1;
        chk(lnk_out_valid[2] && lnk_out_data[2] == 16'hC0DE, "R10 core to link", int'(lnk_out_data[2]), 16'hC0DE);
        chk(core_tx_ready[0], "R10 core ready", int'(core_tx_ready[0]), 1);
        @(negedge clk);
        core_tx_valid[0] = 1'b0;
    endtask

    task automatic t_local();
        cfg(8, 0, 0);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            lnk_in_valid[0] = 1'b1; lnk_in_data[0] = 16'(16'h100 + i); #1;
            if (!lnk_in_ready[0]) chk(0, "R7 accept before full", 0, 1);
        end
        checks++;
        @(negedge clk);
        lnk_in_data[0] = 16'hDEAD; #1;
        chk(!lnk_in_ready[0], "R7 full refuses", int'(lnk_in_ready[0]), 0);
        chk(core_rx_valid[0], "R7 queue has data", int'(core_rx_valid[0]), 1);
        lnk_in_valid[0] = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            core_rx_pop[0] = 1'b1; #1;
            if (!(core_rx_valid[0] && core_rx_data[0] == 16'(16'h100 + i)))
                chk(0, "R7 order", int'(core_rx_data[0]), 16'h100 + i);
        end
        checks++;
        @(negedge clk);
        core_rx_pop[0] = 1'b0; #1;
        chk(!core_rx_valid[0], "R7 drained", int'(core_rx_valid[0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_bypass();
        t_pipe();
        t_multicast();
        t_unused();
        t_core_tx();
        t_local();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule